// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block carries out the compact frame-entry and frame-exit operations of a 32-bit register machine. A decoder hands it one request at a time. The request holds the direction, a three-bit mask that picks the return-address register and the two first callee-saved registers, a count of extra callee-saved registers, a four-bit argument code and the raw frame-size fields. A form bit tells a short encoding from an extended one.

The sequencer walks a fixed list of eighteen register slots. It performs one word access on a request/acknowledge memory port for each slot the request enables. Register values are read from a combinational register-file read port, and reloaded values go back through a registered write port. The operation ends with a single write of the stack-pointer register (r29) and a one-cycle completion pulse. A reserved argument code finishes at once with an error flag and has no side effects.

Loaded words are sign-extended to the register width `XLEN`. The register width defaults to 32.

Top module: `frame_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `rf_we`, `done` and `err` are 0.
- R2: A save first stores r4, r5, r6, r7 (as many as the incoming-argument count) at SP+0, SP+4, SP+8 and SP+12, without moving the running pointer. The argument code sets the count: codes 0 to 3 and 11 give 0, codes 4 to 7 give 1, codes 8 to 10 give 2, codes 12 and 13 give 3, and code 14 gives 4.
- R3: A save then stores words through a running pointer that starts at SP and drops by 4 before each store. The stores go in this order:
  - r31, if `req_ramask[2]` is set;
  - r30, if the extra count is 7;
  - r23 down to r18, where register r(17+k) is included when the extra count is k or more;
  - r17, if `req_ramask[0]` is set;
  - r16, if `req_ramask[1]` is set;
  - r7, r6, r5, r4, as many as the static count. The static count is 0 for codes 0, 4, 8, 12 and 14; 1 for codes 1, 5, 9 and 13; 2 for codes 2, 6 and 10; 3 for codes 3 and 7; and 4 for code 11.
- R4: A save ends by writing SP minus the frame size into r29.
- R5: A restore starts its running pointer at SP plus the frame size. It reloads the registers of R3 in the same order with the same pre-decrement, never reloads incoming arguments, and ends by writing SP plus the frame size into r29.
- R6: With `req_ext`=0, the frame size is 128 bytes when `req_fs_lo` is 0 and 8×`req_fs_lo` otherwise. With `req_ext`=1, it is 8×{`req_fs_hi`,`req_fs_lo`}.
- R7: With `req_ext`=0, `req_xcnt` and `req_acode` are ignored and treated as zero, and code 15 raises no error.
- R8: With `req_ext`=1 and `req_acode`=15, `done` and `err` are both 1 in the cycle after acceptance. No memory access and no register write occurs.
- R9: While `mem_req` is 1 and no acknowledge has arrived, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged. Only one access is outstanding, and `mem_req` falls in the cycle after `mem_ack`.
- R10: `req_ready` is 0 from acceptance until the operation completes. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present, taken when `req_ready` is 1 |
| req_ready | output | 1 | Sequencer idle |
| req_save | input | 1 | 1 = save, 0 = restore |
| req_ext | input | 1 | 1 = extended form |
| req_ramask | input | 3 | bit2 r31, bit1 r16, bit0 r17 |
| req_xcnt | input | 3 | Extra callee-saved register count |
| req_acode | input | 4 | Argument/static code |
| req_fs_hi | input | 4 | Upper frame-size field (extended form) |
| req_fs_lo | input | 4 | Lower frame-size field |
| sp_value | input | XLEN | Current value of r29 |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| done | output | 1 | Completion pulse |
| err | output | 1 | Reserved-code error, with `done` |

## Verification
The properties assume the following about the environment:
- `mem_ack` is raised only while `mem_req` is 1, and only for a single cycle.
- `req_valid` may rise at any time, but the request counts only when `req_ready` is 1.
- The register file does not change under the sequencer during a save.

The bench's memory model acknowledges after 0 to 2 wait cycles and always drops the acknowledge the next cycle. Requests are issued only once `req_ready` is seen. The register model is written only by the sequencer's port while an operation is running.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int NSLOT = 18;
    localparam int IDX_W = $clog2(NSLOT);
    localparam int REG_W = 5;
    localparam logic [REG_W-1:0] SP_REG = 5'd29;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ACCESS,
        ST_FINISH
    } fs_state_e;

    // incoming-argument count per argument code
    function automatic logic [2:0] arg_count(input logic [3:0] code);
        case (code)
            4'd4, 4'd5, 4'd6, 4'd7: arg_count = 3'd1;
            4'd8, 4'd9, 4'd10:      arg_count = 3'd2;
            4'd12, 4'd13:           arg_count = 3'd3;
            4'd14:                  arg_count = 3'd4;
            default:                arg_count = 3'd0;
        endcase
    endfunction

    // static-register count per argument code
    function automatic logic [2:0] static_count(input logic [3:0] code);
        case (code)
            4'd1, 4'd5, 4'd9, 4'd13: static_count = 3'd1;
            4'd2, 4'd6, 4'd10:       static_count = 3'd2;
            4'd3, 4'd7:              static_count = 3'd3;
            4'd11:                   static_count = 3'd4;
            default:                 static_count = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/fs_decode.sv
module fs_decode
    import fs_pkg::*;
#(
    parameter int FS_W = 4,
    localparam int FRAME_W = 2 * FS_W + 3
) (
    input  logic               is_save,
    input  logic               is_ext,
    input  logic [2:0]         ramask,
    input  logic [2:0]         xcnt,
    input  logic [3:0]         acode,
    input  logic [FS_W-1:0]    fs_hi,
    input  logic [FS_W-1:0]    fs_lo,
    output logic [NSLOT-1:0]   slot_en,
    output logic [FRAME_W-1:0] frame_bytes,
    output logic               reserved
);

    logic [2:0] eff_x;
    logic [3:0] eff_a;
    logic [2:0] n_arg;
    logic [2:0] n_stat;

    always_comb begin
        eff_x    = is_ext ? xcnt : 3'd0;
        eff_a    = is_ext ? acode : 4'd0;
        reserved = is_ext && (acode == 4'd15);
        n_arg    = arg_count(eff_a);
        n_stat   = static_count(eff_a);
        if (is_ext)
            frame_bytes = {fs_hi, fs_lo, 3'b000};
        else if (fs_lo == '0)
            frame_bytes = FRAME_W'(1) << (FS_W + 3);
        else
            frame_bytes = FRAME_W'({fs_lo, 3'b000});
    end

    // slots 0..3: incoming arguments, stored by save only
    for (genvar g = 0; g < 4; g++) begin : g_arg
        assign slot_en[g] = is_save && (int'(n_arg) > g);
    end

    assign slot_en[4] = ramask[2];

    // slots 5..11: r30, r23 .. r18
    for (genvar g = 5; g < 12; g++) begin : g_xtra
        localparam int NEED = 12 - g;
        assign slot_en[g] = (int'(eff_x) >= NEED);
    end

    assign slot_en[12] = ramask[0];
    assign slot_en[13] = ramask[1];

    // slots 14..17: static r7 .. r4
    for (genvar g = 14; g < NSLOT; g++) begin : g_stat
        localparam int POS = g - 14;
        assign slot_en[g] = (int'(n_stat) > POS);
    end

endmodule

// File: rtl/fs_slotmap.sv
module fs_slotmap
    import fs_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [REG_W-1:0] reg_num,
    output logic             is_arg
);

    always_comb begin
        is_arg = 1'b0;
        if (idx < IDX_W'(4)) begin
            reg_num = REG_W'(idx) + 5'd4;
            is_arg  = 1'b1;
        end else if (idx == IDX_W'(4)) begin
            reg_num = 5'd31;
        end else if (idx == IDX_W'(5)) begin
            reg_num = 5'd30;
        end else if (idx < IDX_W'(12)) begin
            reg_num = 5'd29 - REG_W'(idx);
        end else if (idx == IDX_W'(12)) begin
            reg_num = 5'd17;
        end else if (idx == IDX_W'(13)) begin
            reg_num = 5'd16;
        end else begin
            reg_num = 5'd21 - REG_W'(idx);
        end
    end

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import fs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int FS_W = 4,
    localparam int FRAME_W = 2 * FS_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_save,
    input  logic             req_ext,
    input  logic [2:0]       req_ramask,
    input  logic [2:0]       req_xcnt,
    input  logic [3:0]       req_acode,
    input  logic [FS_W-1:0]  req_fs_hi,
    input  logic [FS_W-1:0]  req_fs_lo,
    input  logic [XLEN-1:0]  sp_value,
    output logic [REG_W-1:0] rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             rf_we,
    output logic [REG_W-1:0] rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             done,
    output logic             err
);

    typedef struct packed {
        fs_state_e        state;
        logic [IDX_W-1:0] idx;
        logic [NSLOT-1:0] slot_en;
        logic             save;
        logic [XLEN-1:0]  frame;
        logic [XLEN-1:0]  sp;
        logic [XLEN-1:0]  ptr;
        logic             mem_req;
        logic             mem_we;
        logic [XLEN-1:0]  mem_addr;
        logic [31:0]      mem_wdata;
        logic             rf_we;
        logic [REG_W-1:0] rf_waddr;
        logic [XLEN-1:0]  rf_wdata;
        logic             done;
        logic             err;
    } seq_t;

    seq_t q, d;

    logic [NSLOT-1:0]   dec_slot_en;
    logic [FRAME_W-1:0] dec_frame;
    logic               dec_reserved;
    logic [REG_W-1:0]   cur_reg;
    logic               cur_is_arg;
    logic               last_slot;
    logic [XLEN-1:0]    req_frame;

    fs_decode #(.FS_W(FS_W)) i_decode (
        .is_save     (req_save),
        .is_ext      (req_ext),
        .ramask      (req_ramask),
        .xcnt        (req_xcnt),
        .acode       (req_acode),
        .fs_hi       (req_fs_hi),
        .fs_lo       (req_fs_lo),
        .slot_en     (dec_slot_en),
        .frame_bytes (dec_frame),
        .reserved    (dec_reserved)
    );

    fs_slotmap i_slotmap (
        .idx     (q.idx),
        .reg_num (cur_reg),
        .is_arg  (cur_is_arg)
    );

    assign last_slot = (q.idx == IDX_W'(NSLOT - 1));
    assign req_frame = XLEN'(dec_frame);

    always_comb begin
        d = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        d.rf_we = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_reserved) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.state   = ST_SCAN;
                        d.idx     = '0;
                        d.slot_en = dec_slot_en;
                        d.save    = req_save;
                        d.frame   = req_frame;
                        d.sp      = sp_value;
                        d.ptr     = req_save ? sp_value : sp_value + req_frame;
                    end
                end
            end

            ST_SCAN: begin
                if (q.slot_en[q.idx]) begin
                    if (cur_is_arg) begin
                        d.mem_addr = q.sp + XLEN'({q.idx, 2'b00});
                    end else begin
                        d.mem_addr = q.ptr - XLEN'(4);
                        d.ptr      = q.ptr - XLEN'(4);
                    end
                    d.mem_req   = 1'b1;
                    d.mem_we    = q.save;
                    d.mem_wdata = rf_rdata[31:0];
                    d.state     = ST_ACCESS;
                end else if (last_slot) begin
                    d.state = ST_FINISH;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end

            ST_ACCESS: begin
                if (mem_ack) begin
                    d.mem_req = 1'b0;
                    if (!q.save) begin
                        d.rf_we    = 1'b1;
                        d.rf_waddr = cur_reg;
                        d.rf_wdata = XLEN'($signed(mem_rdata));
                    end
                    if (last_slot)
                        d.state = ST_FINISH;
                    else begin
                        d.idx   = q.idx + 1'b1;
                        d.state = ST_SCAN;
                    end
                end
            end

            ST_FINISH: begin
                d.rf_we    = 1'b1;
                d.rf_waddr = SP_REG;
                d.rf_wdata = q.save ? q.sp - q.frame : q.sp + q.frame;
                d.done     = 1'b1;
                d.state    = ST_IDLE;
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == ST_IDLE);
    assign rf_raddr  = cur_reg;
    assign rf_we     = q.rf_we;
    assign rf_waddr  = q.rf_waddr;
    assign rf_wdata  = q.rf_wdata;
    assign mem_req   = q.mem_req;
    assign mem_we    = q.mem_we;
    assign mem_addr  = q.mem_addr;
    assign mem_wdata = q.mem_wdata;
    assign done      = q.done;
    assign err       = q.err;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_ext,
    input logic [3:0]      req_acode,
    input logic            rf_we,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [31:0]     mem_wdata,
    input logic            mem_ack,
    input logic            done,
    input logic            err
);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R9
    mem_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R8
    rsv_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_ext && (req_acode == 4'd15)
        |=> done && err && !mem_req && !rf_we);

endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_frame_seq.sv
module test_frame_seq;

    localparam int XLEN = 32;
    localparam int NV   = 13;
    localparam logic [31:0] SP0 = 32'h0000_0800;

    // {save, ext, ramask[3], xcnt[3], acode[4], fs_hi[4], fs_lo[4], lat[2]}
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd7, 3'd0, 4'd0,  4'h0, 4'h0, 2'd0},
        {1'b0, 1'b0, 3'd7, 3'd0, 4'd0,  4'h0, 4'h0, 2'd1},
        {1'b1, 1'b1, 3'd5, 3'd7, 4'd14, 4'h0, 4'h4, 2'd1},
        {1'b0, 1'b1, 3'd5, 3'd7, 4'd14, 4'h0, 4'h4, 2'd0},
        {1'b1, 1'b1, 3'd2, 3'd3, 4'd11, 4'h1, 4'h0, 2'd2},
        {1'b0, 1'b1, 3'd2, 3'd3, 4'd11, 4'h1, 4'h0, 2'd1},
        {1'b1, 1'b1, 3'd0, 3'd0, 4'd0,  4'h0, 4'h0, 2'd0},
        {1'b1, 1'b1, 3'd3, 3'd6, 4'd7,  4'hF, 4'hF, 2'd2},
        {1'b0, 1'b1, 3'd1, 3'd1, 4'd13, 4'hF, 4'hF, 2'd2},
        {1'b1, 1'b0, 3'd4, 3'd5, 4'd15, 4'h9, 4'h3, 2'd1},
        {1'b0, 1'b1, 3'd6, 3'd2, 4'd9,  4'h2, 4'h5, 2'd0},
        {1'b1, 1'b1, 3'd7, 3'd4, 4'd10, 4'h0, 4'h9, 2'd1},
        {1'b0, 1'b0, 3'd1, 3'd7, 4'd12, 4'h0, 4'h6, 2'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_save = 1'b0;
    logic             req_ext = 1'b0;
    logic [2:0]       req_ramask = '0;
    logic [2:0]       req_xcnt = '0;
    logic [3:0]       req_acode = '0;
    logic [3:0]       req_fs_hi = '0;
    logic [3:0]       req_fs_lo = '0;
    logic [XLEN-1:0]  sp_value;
    logic [4:0]       rf_raddr;
    logic [XLEN-1:0]  rf_rdata;
    logic             rf_we;
    logic [4:0]       rf_waddr;
    logic [XLEN-1:0]  rf_wdata;
    logic             mem_req;
    logic             mem_we;
    logic [XLEN-1:0]  mem_addr;
    logic [31:0]      mem_wdata;
    logic             mem_ack = 1'b0;
    logic [31:0]      mem_rdata = '0;
    logic             done;
    logic             err;

    always #4 clk = ~clk;

    frame_seq #(.XLEN(XLEN)) i_frame_seq (.*);

    // models of register file and memory
    logic [31:0] regs [32];
    logic [31:0] mem  [1024];
    logic [31:0] exp_regs [32];
    logic [31:0] exp_mem  [1024];
    int          lat = 0;
    int          wcnt = 0;
    int          n_acc = 0;
    int          exp_acc = 0;
    logic        unstable = 1'b0;
    logic [31:0] hold_addr, hold_data;
    logic        hold_we;

    assign rf_rdata = regs[rf_raddr];
    assign sp_value = regs[29];

    always @(posedge clk) begin
        if (rf_we) regs[rf_waddr] <= rf_wdata;
    end

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt == 0) begin
                hold_addr <= mem_addr;
                hold_data <= mem_wdata;
                hold_we   <= mem_we;
            end else if (mem_addr != hold_addr || mem_wdata != hold_data || mem_we != hold_we) begin
                unstable <= 1'b1;
            end
            if (wcnt >= lat) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                n_acc    = n_acc + 1;
                if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[11:2]];
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic int nargs(input logic [3:0] c);
        case (c)
            4, 5, 6, 7: return 1;
            8, 9, 10:   return 2;
            12, 13:     return 3;
            14:         return 4;
            default:    return 0;
        endcase
    endfunction

    function automatic int nstat(input logic [3:0] c);
        case (c)
            1, 5, 9, 13: return 1;
            2, 6, 10:    return 2;
            3, 7:        return 3;
            11:          return 4;
            default:     return 0;
        endcase
    endfunction

    task automatic ref_step(input logic sv, input logic [31:0] a, input int rn);
        exp_acc = exp_acc + 1;
        if (sv) exp_mem[a[11:2]] = exp_regs[rn];
        else    exp_regs[rn] = exp_mem[a[11:2]];
    endtask

    // reference model written from R2..R7
    task automatic ref_op(input logic sv, input logic ex, input logic [2:0] rm,
                          input logic [2:0] xc, input logic [3:0] ac,
                          input logic [3:0] hi, input logic [3:0] lo);
        logic [31:0] sp, t, fr;
        if (!ex) begin xc = 0; ac = 0; end
        fr = ex ? {21'd0, hi, lo, 3'b000} : (lo == 0 ? 32'd128 : {25'd0, lo, 3'b000});
        sp = exp_regs[29];
        if (sv) begin
            for (int i = 0; i < nargs(ac); i++) ref_step(1'b1, sp + 32'(4 * i), 4 + i);
            t = sp;
        end else begin
            t = sp + fr;
        end
        if (rm[2]) begin t = t - 4; ref_step(sv, t, 31); end
        for (int k = 7; k >= 1; k--) begin
            if (int'(xc) >= k) begin t = t - 4; ref_step(sv, t, (k == 7) ? 30 : 17 + k); end
        end
        if (rm[0]) begin t = t - 4; ref_step(sv, t, 17); end
        if (rm[1]) begin t = t - 4; ref_step(sv, t, 16); end
        for (int j = 0; j < nstat(ac); j++) begin t = t - 4; ref_step(sv, t, 7 - j); end
        exp_regs[29] = sv ? sp - fr : sp + fr;
    endtask

    task automatic init_state();
        for (int i = 0; i < 32; i++) begin
            regs[i] = {i[7:0], 24'h5A_C300} ^ (i[0] ? 32'h8000_0000 : 32'h0);
        end
        regs[29] = SP0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0BAD_0000 + 32'(i * 32'h0001_0103) ^ (i[1] ? 32'hF000_0000 : 0);
        for (int i = 0; i < 32; i++) exp_regs[i] = regs[i];
        for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
        n_acc    = 0;
        exp_acc  = 0;
        unstable = 1'b0;
    endtask

    task automatic issue(input logic sv, input logic ex, input logic [2:0] rm,
                         input logic [2:0] xc, input logic [3:0] ac,
                         input logic [3:0] hi, input logic [3:0] lo);
        while (!req_ready) @(negedge clk);
        req_save = sv; req_ext = ex; req_ramask = rm; req_xcnt = xc;
        req_acode = ac; req_fs_hi = hi; req_fs_lo = lo; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        int bad_m, bad_r, first;
        bad_m = 0; bad_r = 0; first = -1;
        for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) begin bad_m++; if (first < 0) first = i; end
        chk(bad_m == 0, {tag, " memory"}, (first < 0) ? 0 : mem[first], (first < 0) ? 0 : exp_mem[first]);
        first = -1;
        for (int i = 1; i < 32; i++) if (i != 29 && regs[i] !== exp_regs[i]) begin bad_r++; if (first < 0) first = i; end
        chk(bad_r == 0, {tag, " registers"}, (first < 0) ? 0 : regs[first], (first < 0) ? 0 : exp_regs[first]);
    endtask

    initial begin
        init_state();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
        chk(mem_req === 1'b0 && rf_we === 1'b0, "R1 mem_req/rf_we", {30'd0, mem_req, rf_we}, 0);
        chk(done === 1'b0 && err === 1'b0, "R1 done/err", {30'd0, done, err}, 0);

        for (int v = 0; v < NV; v++) begin
            logic sv, ex;
            logic [2:0] rm, xc;
            logic [3:0] ac, hi, lo;
            string tg;
            {sv, ex, rm, xc, ac, hi, lo} = VEC[v][21:2];
            lat = int'(VEC[v][1:0]);
            init_state();
            ref_op(sv, ex, rm, xc, ac, hi, lo);
            issue(sv, ex, rm, xc, ac, hi, lo);
            // R10: busy once accepted
            chk(req_ready === 1'b0, "R10 ready low while busy", 32'(req_ready), 0);
            while (!done) @(negedge clk);
            chk(err === 1'b0, ex ? "R8 no error on valid code" : "R7 short form ignores code", 32'(err), 0);
            @(negedge clk);
            // R10: done lasts one cycle
            chk(done === 1'b0, "R10 done pulse", 32'(done), 0);
            tg = sv ? "R2/R3 save" : "R5 restore";
            compare_all(tg);
            // R4/R5/R6: final stack pointer from the frame size encoding
            chk(regs[29] === exp_regs[29], sv ? "R4/R6 save SP" : "R5/R6 restore SP", regs[29], exp_regs[29]);
            chk(n_acc == exp_acc, sv ? "R3 access count" : "R5 access count", 32'(n_acc), 32'(exp_acc));
            chk(!unstable, "R9 port stable until ack", 32'(unstable), 0);
        end

        // R8: reserved code in extended form
        init_state();
        issue(1'b1, 1'b1, 3'd7, 3'd7, 4'd15, 4'h3, 4'h3);
        chk(done === 1'b1 && err === 1'b1, "R8 done+err after accept", {30'd0, done, err}, 3);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk(n_acc == 0, "R8 no memory access", 32'(n_acc), 0);
        compare_all("R8 reserved");
        chk(regs[29] === SP0, "R8 SP unchanged", regs[29], SP0);

        // R8: reserved restore also aborts
        issue(1'b0, 1'b1, 3'd1, 3'd0, 4'd15, 4'h0, 4'h1);
        chk(done === 1'b1 && err === 1'b1, "R8 restore abort", {30'd0, done, err}, 3);
        @(negedge clk);
        chk(n_acc == 0 && regs[29] === SP0, "R8 restore no effect", regs[29], SP0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule